// File: doc/BRIEF.md
# Quantized Float Field Encoder

This block turns one single-precision floating-point bit pattern into a compact float made of a narrow exponent field and a digit field. The digit field can carry a sign bit. Both fields are placed at configurable bit positions inside a physical word of parameterized width. The block also produces a write mask that covers exactly those two fields, so that a later read-modify-write stage can merge the result into memory without touching the neighbouring fields.

Rounding is done by adding half of a digit LSB to the whole 32-bit input pattern before any field is cut out. A mantissa that rounds up past its top therefore carries into the exponent on its own. The exponent is rebased by a conversion offset, clamped at zero and saturated at the largest code of its field. A stored exponent of zero flushes the whole digit field, sign included, to zero.

Parameters set the digit count, the exponent width, the conversion offset, signedness, the word width and both field positions. Parameter sets whose fields overlap or fall outside the word are refused at elaboration. There is one register stage between input and output.

Top module: `qflt_encoder`

## Requirements
- R1: Before any field is extracted, 1 << (22 − DIG_W) is added to the 32-bit input pattern whenever DIG_W < 23. A carry out of the mantissa raises the exponent, and the digits come out rounded to the nearest value.
- R2: The raw exponent is bits [30:23] of the rounded pattern. The digits are the DIG_W bits directly below bit 23 of the rounded pattern.
- R3: When the raw exponent is nonzero, EXP_OFS is subtracted from it. A raw exponent of zero stays zero, and a result of zero or below is stored as 0.
- R4: A rebased exponent greater than 2^EXP_W − 1 is stored as the all-ones code of the EXP_W-bit field.
- R5: When the stored exponent is zero, every bit of the digit field is zero, the sign bit included.
- R6: With SIGNED=1, bit 31 of the input sits at bit DIG_W of the digit field, just above the magnitude digits. The digit field is then DIG_W+1 bits wide.
- R7: packed_word holds the exponent field at bits [EXP_POS +: EXP_W] and the digit field at bits [DIG_POS +: digit field width]. Every other bit is zero.
- R8: While out_valid is 1, mask has ones exactly over the two field ranges of R7. While out_valid is 0, mask is all zeros.
- R9: out_valid follows in_valid one clock later. packed_word updates only in the cycle after an accepted input and otherwise holds its value.
- R10: While rst_n is low, out_valid, packed_word and mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pattern is present this cycle |
| in_float | input | 32 | Single-precision bit pattern to encode |
| out_valid | output | 1 | packed_word and mask carry a new result |
| packed_word | output | WORD_W | Encoded fields at their positions, zeros elsewhere |
| mask | output | WORD_W | Ones over the exponent and digit fields while out_valid is 1 |

## Verification
The bound checker looks at the following on every cycle:
- the one-cycle valid relation and the hold of packed_word between inputs;
- the mask, compared against a bit-by-bit rebuild of the field ranges;
- that no bit outside the two fields is ever set;
- that an exponent field of zero always comes with an empty digit field.

Some behaviours depend on the value of the input pattern and only the bench's vectors can show them:
- the rounding carry into the exponent;
- the rounding inside the mantissa;
- the position of the sign;
- the clamp when the raw exponent is at or below the offset;
- saturation at and just above the top exponent code.

// File: rtl/qfe_pkg.sv
package qfe_pkg;

   localparam int F32_W       = 32;
   localparam int F32_EXP_W   = 8;
   localparam int F32_FRAC_W  = 23;
   localparam int F32_SIGN_IX = 31;

   typedef struct packed {
      logic                  sign;
      logic [F32_EXP_W-1:0]  exp;
      logic [F32_FRAC_W-1:0] frac;
   } f32_bits_t;

endpackage

// File: rtl/qfe_round_split.sv
module qfe_round_split
   import qfe_pkg::*;
#(
   parameter int DIG_W = 8
) (
   input  logic [F32_W-1:0]     pattern,
   output logic [F32_EXP_W-1:0] raw_exp,
   output logic [DIG_W-1:0]     digits,
   output logic                 sign
);

   f32_bits_t rounded;
   logic      unused_rounded;

   generate
      if (DIG_W < F32_FRAC_W) begin : g_round
         localparam logic [F32_W-1:0] HALF_LSB = F32_W'(1) << (F32_FRAC_W - 1 - DIG_W);
         assign rounded = pattern + HALF_LSB;
      end else begin : g_exact
         assign rounded = pattern;
      end
   endgenerate

   assign raw_exp        = rounded.exp;
   assign digits         = rounded.frac[F32_FRAC_W-1 -: DIG_W];
   assign sign           = rounded.sign;
   assign unused_rounded = ^rounded;

endmodule

// File: rtl/qfe_exp_map.sv
module qfe_exp_map
   import qfe_pkg::*;
#(
   parameter int EXP_W   = 5,
   parameter int EXP_OFS = 112
) (
   input  logic [F32_EXP_W-1:0] raw_exp,
   output logic [EXP_W-1:0]     stored_exp
);

   localparam int DIFF_W   = F32_EXP_W + 2;
   localparam int MAX_CODE = (1 << EXP_W) - 1;

   logic signed [DIFF_W-1:0] diff;

   always_comb begin
      diff = $signed({2'b00, raw_exp}) - $signed(DIFF_W'(EXP_OFS));
      if (raw_exp == '0) begin
         stored_exp = '0;
      end else if (diff <= 0) begin
         stored_exp = '0;
      end else if (diff > $signed(DIFF_W'(MAX_CODE))) begin
         stored_exp = EXP_W'(MAX_CODE);
      end else begin
         stored_exp = diff[EXP_W-1:0];
      end
   end

endmodule

// File: rtl/qfe_pack.sv
module qfe_pack #(
   parameter int DIG_W   = 8,
   parameter int EXP_W   = 5,
   parameter bit SIGNED  = 1'b1,
   parameter int WORD_W  = 32,
   parameter int EXP_POS = 20,
   parameter int DIG_POS = 4,
   localparam int FLD_W  = DIG_W + (SIGNED ? 1 : 0)
) (
   input  logic [EXP_W-1:0]  stored_exp,
   input  logic [DIG_W-1:0]  digits,
   input  logic              sign,
   output logic [WORD_W-1:0] word
);

   logic [FLD_W-1:0] field_raw;
   logic [FLD_W-1:0] field;

   generate
      if (SIGNED) begin : g_signed
         assign field_raw = {sign, digits};
      end else begin : g_unsigned
         logic unused_sign;
         assign unused_sign = sign;
         assign field_raw   = digits;
      end
   endgenerate

   assign field = (stored_exp == '0) ? '0 : field_raw;

   assign word = (WORD_W'(stored_exp) << EXP_POS) | (WORD_W'(field) << DIG_POS);

endmodule

// File: rtl/qflt_encoder.sv
module qflt_encoder
   import qfe_pkg::*;
#(
   parameter int DIG_W   = 8,
   parameter int EXP_W   = 5,
   parameter int EXP_OFS = 112,
   parameter bit SIGNED  = 1'b1,
   parameter int WORD_W  = 32,
   parameter int EXP_POS = 20,
   parameter int DIG_POS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [F32_W-1:0]  in_float,
   output logic              out_valid,
   output logic [WORD_W-1:0] packed_word,
   output logic [WORD_W-1:0] mask
);

   localparam int FLD_W = DIG_W + (SIGNED ? 1 : 0);
   localparam logic [WORD_W-1:0] EXP_MASK = WORD_W'((1 << EXP_W) - 1) << EXP_POS;
   localparam logic [WORD_W-1:0] DIG_MASK = WORD_W'((1 << FLD_W) - 1) << DIG_POS;
   localparam logic [WORD_W-1:0] FLD_MASK = EXP_MASK | DIG_MASK;

   generate
      if (DIG_W < 1 || DIG_W > F32_FRAC_W) begin : g_bad_dig
         $error("qflt_encoder: DIG_W must lie in 1..23");
      end
      if (EXP_W < 1 || EXP_W > F32_EXP_W) begin : g_bad_exp
         $error("qflt_encoder: EXP_W must lie in 1..8");
      end
      if (EXP_OFS < 0 || EXP_OFS > 255) begin : g_bad_ofs
         $error("qflt_encoder: EXP_OFS must lie in 0..255");
      end
      if (EXP_POS < 0 || EXP_POS + EXP_W > WORD_W ||
          DIG_POS < 0 || DIG_POS + FLD_W > WORD_W) begin : g_bad_fit
         $error("qflt_encoder: a field does not fit in the word");
      end
      if ((EXP_MASK & DIG_MASK) != '0) begin : g_overlap
         $error("qflt_encoder: exponent and digit fields overlap");
      end
   endgenerate

   logic [F32_EXP_W-1:0] raw_exp;
   logic [DIG_W-1:0]     digits;
   logic                 sign;
   logic [EXP_W-1:0]     stored_exp;
   logic [WORD_W-1:0]    word_nxt;

   qfe_round_split #(.DIG_W(DIG_W)) u_split (
      .pattern (in_float),
      .raw_exp (raw_exp),
      .digits  (digits),
      .sign    (sign)
   );

   qfe_exp_map #(.EXP_W(EXP_W), .EXP_OFS(EXP_OFS)) u_exp (
      .raw_exp    (raw_exp),
      .stored_exp (stored_exp)
   );

   qfe_pack #(
      .DIG_W(DIG_W), .EXP_W(EXP_W), .SIGNED(SIGNED),
      .WORD_W(WORD_W), .EXP_POS(EXP_POS), .DIG_POS(DIG_POS)
   ) u_pack (
      .stored_exp (stored_exp),
      .digits     (digits),
      .sign       (sign),
      .word       (word_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         packed_word <= '0;
         mask        <= '0;
      end else begin
         out_valid <= in_valid;
         mask      <= in_valid ? FLD_MASK : '0;
         if (in_valid) begin
            packed_word <= word_nxt;
         end
      end
   end

endmodule

// File: rtl/qfe_checker.sv
module qfe_checker #(
   parameter int DIG_W   = 8,
   parameter int EXP_W   = 5,
   parameter bit SIGNED  = 1'b1,
   parameter int WORD_W  = 32,
   parameter int EXP_POS = 20,
   parameter int DIG_POS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic [WORD_W-1:0] packed_word,
   input logic [WORD_W-1:0] mask
);

   localparam int FW = DIG_W + (SIGNED ? 1 : 0);

   logic [WORD_W-1:0] ref_mask;

   always_comb begin
      for (int i = 0; i < WORD_W; i++) begin
         ref_mask[i] = (i >= EXP_POS && i < EXP_POS + EXP_W) ||
                       (i >= DIG_POS && i < DIG_POS + FW);
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(packed_word));
   a_r8_mask_on: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (mask == ref_mask));
   a_r8_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (mask == '0));
   a_r7_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (packed_word & ~ref_mask) == '0);
   a_r5_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (packed_word[EXP_POS +: EXP_W] == '0) |-> (packed_word[DIG_POS +: FW] == '0));

endmodule

bind qflt_encoder qfe_checker #(
   .DIG_W(DIG_W), .EXP_W(EXP_W), .SIGNED(SIGNED),
   .WORD_W(WORD_W), .EXP_POS(EXP_POS), .DIG_POS(DIG_POS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .packed_word (packed_word),
   .mask        (mask)
);

// File: tb/sim_qflt_encoder.sv
`timescale 1ns/1ps
module sim_qflt_encoder;

   localparam int W = 32;
   localparam logic [W-1:0] FMASK = 32'h01F0_1FF0;
   localparam int NV = 12;

   // {input pattern, expected packed word}; defaults D=8, E=5, offset 112, signed,
   // exponent at bits 24:20, 9-bit digit field at bits 12:4
   localparam logic [63:0] VECS [NV] = '{
      64'h3F800000_00F00000,  // R2 exponent 127 -> 15, digits 0
      64'hBFC00000_00F01800,  // R6 sign lands above digits 0x80
      64'h3FFFFFFF_01000000,  // R1 rounding carry into exponent
      64'h3F80C000_00F00020,  // R1 round to nearest inside mantissa
      64'h00000000_00000000,  // R3 raw zero stays zero
      64'hB2123456_00000000,  // R5 clamp to zero flushes sign and digits
      64'h38FF8000_00100FF0,  // R3 raw 113 -> 1
      64'h387F0000_00000000,  // R3 raw 112 -> 0, flushed
      64'hC7800000_01F01000,  // R4 raw 143 -> 31 exactly
      64'h64000000_01F00000,  // R4 raw 200 saturates
      64'h3FD50000_00F00AA0,  // R7 digit placement 0xAA
      64'h48000000_01F00000   // R4 raw 144 saturates
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  in_float = '0;
   logic         out_valid;
   logic [W-1:0] packed_word;
   logic [W-1:0] mask;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   qflt_encoder u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_float    (in_float),
      .out_valid   (out_valid),
      .packed_word (packed_word),
      .mask        (mask)
   );

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   initial begin
      #(200000 * 5);
      total++;
      bad++;
      $display("FAIL watchdog got=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 out_valid", W'(out_valid), '0);
      chk("R10 packed_word", packed_word, '0);
      chk("R10 mask", mask, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         in_valid = 1'b1;
         in_float = VECS[i][63:32];
         @(negedge clk);
         chk($sformatf("R9 valid vec%0d", i), W'(out_valid), W'(1));
         chk($sformatf("vec%0d word", i), packed_word, VECS[i][31:0]);
         chk($sformatf("R8 mask vec%0d", i), mask, FMASK);
      end

      // R8 R9 idle cycle: no valid, mask clear, word held
      in_valid = 1'b0;
      in_float = 32'h3F800000;
      @(negedge clk);
      chk("R9 idle out_valid", W'(out_valid), '0);
      chk("R8 idle mask", mask, '0);
      chk("R9 word held", packed_word, VECS[NV-1][31:0]);
      in_float = 32'hBFC00000;
      @(negedge clk);
      chk("R9 word held after input change", packed_word, VECS[NV-1][31:0]);

      // R9 single valid after idle
      in_valid = 1'b1;
      in_float = 32'h3F800000;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 single valid", W'(out_valid), W'(1));
      chk("R2 single word", packed_word, 32'h00F00000);
      @(negedge clk);
      chk("R9 valid drops", W'(out_valid), '0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule